// File: doc/BRIEF.md
# Transmit Line Format Detector

This block sits at the transmit data input of a 1.544 Mb/s line interface. On each falling edge of the transmit clock it samples two pins. In its default bipolar format, a high on the positive-request pin asks for a positive mark and a high on the negative-request pin asks for a negative mark. The block turns these into registered pulse requests for the line driver.

The block picks its data format on the fly, with no configuration register. It counts how many consecutive samples of the negative-request pin are high. When that run reaches a threshold (16 samples by default), the block switches to single-line NRZ format. In that format the positive-request pin carries the data. Each one becomes a mark of alternating polarity, and each zero becomes no pulse. The first low sample on the negative-request pin puts the block back in bipolar format. A registered mode flag shows which format is in force.

Top module: `tx_format_detector`

## Requirements
- R1: Both data pins are sampled on the falling edge of `clk_i`. All three outputs are registers that update on that same falling edge and hold their value until the next falling edge.
- R2: In bipolar format, `tx_p_i`=1 with `tx_n_i`=0 gives `mark_pos_o`=1 and `mark_neg_o`=0. `tx_n_i`=1 with `tx_p_i`=0 gives `mark_neg_o`=1 and `mark_pos_o`=0. Both low gives no mark.
- R3: In bipolar format, both pins high gives no mark on either output.
- R4: `unipolar_o` (1 = single-line format, 0 = bipolar) goes to 1 on the edge that samples the RUN_LEN-th consecutive high on `tx_n_i` (default 16). After only RUN_LEN-1 consecutive highs it stays 0.
- R5: A low sample on `tx_n_i` puts the block in bipolar format on that same edge and restarts the run. Re-entry needs another full RUN_LEN consecutive highs.
- R6: In single-line format, a 1 on `tx_p_i` gives one mark. Marks alternate in polarity, and the first mark after entering the format is positive. A 0 gives no mark and leaves the alternation unchanged.
- R7: `mark_pos_o` and `mark_neg_o` are never high together.
- R8: While `rst_ni` is low at a falling edge, both marks and `unipolar_o` clear and the run count restarts from zero.
- R9: If `tx_n_i` stays high far beyond the threshold (longer than the run counter's range), the block stays in single-line format. The counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Transmit clock; data sampled on its falling edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| tx_p_i | input | 1 | Positive mark request, or NRZ data in single-line format |
| tx_n_i | input | 1 | Negative mark request; a long high run selects single-line format |
| mark_pos_o | output | 1 | Registered positive pulse request |
| mark_neg_o | output | 1 | Registered negative pulse request |
| unipolar_o | output | 1 | Registered format flag: 1 single-line, 0 bipolar |

## Verification
On every falling edge, the assertions check four things:
- the two marks never overlap;
- a low negative-request sample forces bipolar format and clears the run;
- bipolar requests map to marks, and both-high gives nothing;
- single-line zeros give no mark, and successive single-line ones flip polarity.

Other behaviours only the bench scenarios can show:
- entry after exactly RUN_LEN highs but not RUN_LEN-1;
- the positive first mark after entry;
- persistence through a run long enough to saturate the counter;
- the one-edge output timing against a reference model.

// File: rtl/tx_fmt_pkg.sv
// Package: shared types for the transmit format detector.
// Assumes: one mark request at most per transmit clock period.
package tx_fmt_pkg;

    // Data format currently in force
    typedef enum logic {
        FMT_BIPOLAR  = 1'b0,
        FMT_UNIPOLAR = 1'b1
    } fmt_e;

    // One pulse request toward the line driver
    typedef struct packed {
        logic pos;
        logic neg;
    } mark_t;

    localparam mark_t MARK_NONE = '{pos: 1'b0, neg: 1'b0};
    localparam mark_t MARK_POS  = '{pos: 1'b1, neg: 1'b0};
    localparam mark_t MARK_NEG  = '{pos: 1'b0, neg: 1'b1};

endpackage

// File: rtl/txf_run_counter.sv
// Module: txf_run_counter
// Counts consecutive high samples of the negative-request pin and reports,
// combinationally, whether the current sample completes a run of RUN_LEN.
// Assumes: the sampling edge is the falling edge of clk_i; the count saturates
// at its all-ones value so an endless run never wraps back below threshold.
module txf_run_counter #(
    parameter int RUN_LEN = 16,
    parameter int CNT_W   = $clog2(RUN_LEN) + 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic reach_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_TRIP = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count: clear on a low sample, otherwise increment up to saturation
    always_comb begin
        if (!level_i) begin
            cnt_d = '0;
        end else if (cnt_q == CNT_MAX) begin
            cnt_d = CNT_MAX;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // Run count register, updated on the sampling edge
    always_ff @(negedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Current sample is the RUN_LEN-th (or later) consecutive high
    assign reach_o = level_i && (cnt_q >= CNT_TRIP);

    // R5: a low sample restarts the run
    assert_run_clear_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !level_i |=> (cnt_q == '0));

    // R9: a saturated count stays saturated while the pin stays high
    assert_run_saturate_R9: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (cnt_q == CNT_MAX && level_i) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/txf_mark_encoder.sv
// Module: txf_mark_encoder
// Turns one sampled pin pair into a registered mark request. In bipolar format
// each pin asks for its own polarity and a pair of highs cancels. In
// single-line format the positive pin carries NRZ data, coded with
// alternate mark inversion.
// Assumes: fmt_i is valid for the same sample as the data pins.
module txf_mark_encoder
    import tx_fmt_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  fmt_e  fmt_i,
    input  logic  data_p_i,
    input  logic  data_n_i,
    output mark_t mark_o
);
    logic  next_neg_q;   // polarity of the next single-line mark: 1 = negative
    mark_t mark_d;
    logic  next_neg_d;

    // Mark selection and polarity bookkeeping for the current sample
    always_comb begin
        next_neg_d = 1'b0;
        mark_d     = MARK_NONE;
        if (fmt_i == FMT_UNIPOLAR) begin
            next_neg_d = next_neg_q;
            if (data_p_i) begin
                mark_d     = next_neg_q ? MARK_NEG : MARK_POS;
                next_neg_d = !next_neg_q;
            end
        end else begin
            unique case ({data_p_i, data_n_i})
                2'b10:   mark_d = MARK_POS;
                2'b01:   mark_d = MARK_NEG;
                default: mark_d = MARK_NONE;
            endcase
        end
    end

    // Output mark and polarity registers, updated on the sampling edge
    always_ff @(negedge clk_i) begin
        if (!rst_ni) begin
            mark_o     <= MARK_NONE;
            next_neg_q <= 1'b0;
        end else begin
            mark_o     <= mark_d;
            next_neg_q <= next_neg_d;
        end
    end

    // R6: a single-line zero never yields a mark
    assert_uni_zero_quiet_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (fmt_i == FMT_UNIPOLAR && !data_p_i) |=> (mark_o == MARK_NONE));

    // R6: a positive single-line mark is followed by a negative one on the next one
    assert_uni_alternate_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (fmt_i == FMT_UNIPOLAR && data_p_i && mark_o.pos && $past(fmt_i) == FMT_UNIPOLAR)
        |=> mark_o.neg);

    // R3: both pins high in bipolar format cancel
    assert_bip_cancel_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (fmt_i == FMT_BIPOLAR && data_p_i && data_n_i) |=> (mark_o == MARK_NONE));

endmodule

// File: rtl/tx_format_detector.sv
// Module: tx_format_detector (top)
// Samples the two transmit request pins on the falling edge of the transmit
// clock. It selects bipolar or single-line NRZ format from the length of the
// current high run on the negative pin, and registers the mark requests and
// the format flag on that same edge.
// Assumes: clk_i is the transmit clock (nominally 1.544 MHz); reset is
// synchronous and sampled on the falling edge.
module tx_format_detector
    import tx_fmt_pkg::*;
#(
    parameter int RUN_LEN = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tx_p_i,
    input  logic tx_n_i,
    output logic mark_pos_o,
    output logic mark_neg_o,
    output logic unipolar_o
);
    localparam int CNT_W = $clog2(RUN_LEN) + 1;

    logic  reach;
    fmt_e  fmt_now;
    fmt_e  fmt_q;
    mark_t mark;

    txf_run_counter #(
        .RUN_LEN (RUN_LEN),
        .CNT_W   (CNT_W)
    ) i_run (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (tx_n_i),
        .reach_o (reach)
    );

    // Format in force for the current sample
    assign fmt_now = reach ? FMT_UNIPOLAR : FMT_BIPOLAR;

    txf_mark_encoder i_enc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .fmt_i    (fmt_now),
        .data_p_i (tx_p_i),
        .data_n_i (tx_n_i),
        .mark_o   (mark)
    );

    // Registered format flag, same edge as the marks
    always_ff @(negedge clk_i) begin
        if (!rst_ni) begin
            fmt_q <= FMT_BIPOLAR;
        end else begin
            fmt_q <= fmt_now;
        end
    end

    assign mark_pos_o = mark.pos;
    assign mark_neg_o = mark.neg;
    assign unipolar_o = (fmt_q == FMT_UNIPOLAR);

    // R7: marks never overlap
    assert_mark_exclusive_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !(mark_pos_o && mark_neg_o));

    // R5: a low negative-pin sample forces bipolar format
    assert_exit_bipolar_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !tx_n_i |=> !unipolar_o);

    // R2: a lone positive request in bipolar format gives a positive mark
    assert_bip_pos_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (tx_p_i && !tx_n_i) |=> (mark_pos_o && !mark_neg_o));

    // R9: single-line format persists while the negative pin stays high
    assert_hold_unipolar_R9: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (unipolar_o && tx_n_i) |=> unipolar_o);

endmodule

// File: tb/test_tx_format_detector.sv
module test_tx_format_detector;

    localparam int RUN_LEN = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_p = 1'b0;
    logic tx_n = 1'b0;
    logic mark_pos, mark_neg, unipolar;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_run = 0;
    bit m_negnext = 1'b0;
    bit e_pos, e_neg, e_uni;

    tx_format_detector #(.RUN_LEN(RUN_LEN)) i_tx_format_detector (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tx_p_i     (tx_p),
        .tx_n_i     (tx_n),
        .mark_pos_o (mark_pos),
        .mark_neg_o (mark_neg),
        .unipolar_o (unipolar)
    );

    always #5 clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // format selected for a sample, given the prior run
    function automatic bit fmt_for(bit n, int run);
        return n && (run + 1 >= RUN_LEN);
    endfunction

    // advance the model by one sample
    function automatic void model_step(bit p, bit n);
        e_uni = fmt_for(n, m_run);
        m_run = n ? m_run + 1 : 0;
        if (e_uni) begin
            e_pos = p && !m_negnext;
            e_neg = p && m_negnext;
            if (p) m_negnext = !m_negnext;
        end else begin
            m_negnext = 1'b0;
            e_pos = p && !n;
            e_neg = n && !p;
        end
    endfunction

    // drive one sample just after a rising edge, read results at the next rising edge
    task automatic step(bit p, bit n, string req);
        tx_p = p;
        tx_n = n;
        @(posedge clk);
        #1;
        model_step(p, n);
        check(req, "mark_pos", int'(mark_pos), int'(e_pos));
        check(req, "mark_neg", int'(mark_neg), int'(e_neg));
        check(req, "unipolar", int'(unipolar), int'(e_uni));
        check("R7", "overlap", int'(mark_pos && mark_neg), 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R8: reset with busy inputs
        tx_p = 1'b1;
        tx_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R8", "mark_pos", int'(mark_pos), 0);
        check("R8", "mark_neg", int'(mark_neg), 0);
        check("R8", "unipolar", int'(unipolar), 0);
        rst_n = 1'b1;
        tx_n = 1'b0;
        step(1'b0, 1'b0, "R8");

        // R1: output holds until the falling edge, then updates
        tx_p = 1'b1;
        tx_n = 1'b0;
        #2;
        check("R1", "mark_pos before edge", int'(mark_pos), 0);
        @(negedge clk);
        #1;
        check("R1", "mark_pos after edge", int'(mark_pos), 1);
        @(posedge clk);
        #1;
        model_step(1'b1, 1'b0);

        // R2 / R3 bipolar patterns
        step(1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, "R2");
        step(1'b0, 0, "R2");
        step(1'b1, 1'b1, "R3");
        step(1'b1, 1'b0, "R2");

        // R4: RUN_LEN-1 highs stay bipolar, then a low, then full run
        for (int i = 0; i < RUN_LEN - 1; i++) step(1'b0, 1'b1, "R4");
        check("R4", "short run", int'(unipolar), 0);
        step(1'b0, 1'b0, "R5");
        for (int i = 0; i < RUN_LEN - 1; i++) step(1'b0, 1'b1, "R5");
        check("R5", "restarted run", int'(unipolar), 0);
        step(1'b1, 1'b1, "R4");
        check("R4", "entry flag", int'(unipolar), 1);
        check("R6", "first mark positive", int'(mark_pos), 1);
        // R6 alternation with zeros between
        step(1'b0, 1'b1, "R6");
        step(1'b1, 1'b1, "R6");
        step(1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, "R6");
        step(1'b1, 1'b1, "R6");
        step(1'b1, 1'b1, "R6");
        // R9: long run past counter range
        for (int i = 0; i < 3 * RUN_LEN; i++) step(1'($urandom_range(0, 1)), 1'b1, "R9");
        check("R9", "still unipolar", int'(unipolar), 1);
        // R5: exit on one low sample
        step(1'b1, 1'b0, "R5");
        check("R5", "exit flag", int'(unipolar), 0);

        // random runs of the negative pin
        for (int k = 0; k < 400; k++) begin
            int len = $urandom_range(0, RUN_LEN + 12);
            for (int i = 0; i < len; i++) begin
                bit p = 1'($urandom_range(0, 1));
                step(p, 1'b1, fmt_for(1'b1, m_run) ? "R6" : "R4");
            end
            for (int i = 0; i < int'($urandom_range(1, 3)); i++)
                step(1'($urandom_range(0, 1)), 1'b0, "R2");
        end

        // R8: reset mid single-line format
        for (int i = 0; i < RUN_LEN + 2; i++) step(1'b1, 1'b1, "R6");
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R8", "unipolar in reset", int'(unipolar), 0);
        check("R8", "marks in reset", int'(mark_pos || mark_neg), 0);
        rst_n = 1'b1;
        m_run = 0;
        m_negnext = 1'b0;
        step(1'b0, 1'b1, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule